// File: doc/BRIEF.md
# HDLC Receive Frame Status Unit

This block receives a serial HDLC bit stream that arrives with a one-cycle bit enable. It finds the flags that delimit frames, deletes stuffed zeros, and assembles the remaining bits into bytes, least significant bit first. Each completed byte is pushed to an external receive FIFO through a one-cycle write strobe. The FIFO's full flag decides whether a byte is stored or lost. The block also runs the 16-bit frame check over every data bit. It compares the first received byte, which is the high address byte, against two programmable values and two fixed group values.

When an accepted frame ends, either on a closing flag or on an abort, the block pulses `stat_vld` for one cycle and updates `stat_byte`. From bit 7 down to bit 0, the status fields are: frame valid, data overflow, check sequence good, aborted, a two-bit high-address match code, the command/response bit, and the low-address flag. A frame is never reported if its first byte was lost to a full FIFO. When address checking is on, a frame whose first byte matches nothing is also never reported. Nothing of such a frame is written to the FIFO.

Top module: `hdlc_rx_status`

## Requirements
- R1: After reset, `stat_byte` is 0x0E and `wr_en` and `stat_vld` are low.
- R2: On the received stream, a 0 that follows five 1s is deleted. The pattern 0111_1110 is a flag. A single flag between two frames closes the first frame and opens the second. Flags with no data between them produce no strobe. A closing flag of an accepted frame produces exactly one `stat_vld` pulse.
- R3: Each completed byte of an accepted frame is written with one `wr_en` pulse, in arrival order, the first received bit in bit 0. The two check-sequence bytes are written too. `wr_en` is never high in two consecutive cycles.
- R4: Status bit 7 (valid) is 1 when the destuffed bit count between the two flags is a multiple of 8, and 0 otherwise.
- R5: Status bit 5 is 1 when the check over all destuffed bits between the flags leaves the residue 0xF0B8, and 0 otherwise. The check is CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB first and preset to all ones. The transmitter sends the inverted CRC, low byte first.
- R6: Seven consecutive 1s inside an accepted frame end it. The status then has bit 4 = 1 and bits 7 and 5 = 0. Other fields keep their meaning.
- R7: When `addr_chk` is 1, status bits 3:2 are 2'b10 if the first byte equals `hi_addr1`, else 2'b00 if it equals `hi_addr2`, else 2'b01 if it is 0xFE or 0xFC. A frame matching none of these produces no write and no strobe.
- R8: When `addr_chk` is 0, every frame is accepted and status bits 3:2 are 2'b11.
- R9: A byte other than the first that completes while `fifo_full` is high is dropped. The frame's status then has bit 6 = 1.
- R10: If `fifo_full` is high when the first byte completes, the frame is dropped entirely: no writes and no strobe.
- R11: Status bit 1 equals bit 1 of the first byte. Status bit 0 equals bit 0 of the second byte, or 0 if the frame has fewer than two bytes.
- R12: `stat_byte` holds its value between strobes. `stat_vld` and `wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Bit enable; `rx_bit` is taken when high |
| rx_bit | input | 1 | Serial line bit |
| addr_chk | input | 1 | Enable high-address recognition |
| hi_addr1 | input | 8 | First programmable high address |
| hi_addr2 | input | 8 | Second programmable high address |
| fifo_full | input | 1 | External receive FIFO is full |
| wr_en | output | 1 | Write strobe to the FIFO |
| wr_data | output | 8 | Byte to write |
| stat_vld | output | 1 | One-cycle frame-end strobe |
| stat_byte | output | 8 | Status of the last reported frame |

## Verification
Several internal faults show up at the ports within one frame. A wrong ones count or a wrong delay-line fill shifts every byte boundary, so the very next FIFO write carries a wrong value. That same fault also clears the valid and check bits at the next closing flag. A stale acceptance or overflow flag leaks into the following frame's status, one frame later. The sweeps over every first-byte value and every FIFO limit cover each acceptance path.

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status #(
  parameter logic [7:0]  GRP0     = 8'hFE,
  parameter logic [7:0]  GRP1     = 8'hFC,
  parameter logic [15:0] POLY     = 16'h8408,
  parameter logic [15:0] RESIDUE  = 16'hF0B8,
  parameter logic [7:0]  STAT_RST = 8'h0E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_bit,
  input  logic       addr_chk,
  input  logic [7:0] hi_addr1,
  input  logic [7:0] hi_addr2,
  input  logic       fifo_full,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       stat_vld,
  output logic [7:0] stat_byte
);

  logic [2:0]  ones;
  logic [5:0]  dly;
  logic [2:0]  fill;
  logic        in_frm, acc, ovf, cr, la;
  logic [15:0] crc;
  logic [2:0]  bcnt;
  logic [1:0]  nb, code;
  logic [7:0]  sr;

  wire        push      = rx_en && in_frm && (ones < 3'd5);
  wire        commit    = push && (fill == 3'd6);
  wire        cbit      = dly[0];
  wire        flag_hit  = rx_en && (ones == 3'd6) && !rx_bit;
  wire        abort_hit = rx_en && (ones == 3'd6) && rx_bit;
  wire [7:0]  byte_n    = {cbit, sr[7:1]};
  wire        byte_done = commit && (bcnt == 3'd7);
  wire        first     = byte_done && (nb == 2'd0);
  wire        m1        = byte_n == hi_addr1;
  wire        m2        = byte_n == hi_addr2;
  wire        mg        = (byte_n == GRP0) || (byte_n == GRP1);
  wire        hit       = !addr_chk || m1 || m2 || mg;
  wire [1:0]  code_n    = !addr_chk ? 2'b11 : m1 ? 2'b10 : m2 ? 2'b00 : 2'b01;
  wire [15:0] crc_n     = {1'b0, crc[15:1]} ^ ({16{crc[0] ^ cbit}} & POLY);
  wire        crc_ok    = crc == RESIDUE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones      <= '0;
      dly       <= '0;
      fill      <= '0;
      in_frm    <= 1'b0;
      acc       <= 1'b0;
      ovf       <= 1'b0;
      cr        <= 1'b0;
      la        <= 1'b0;
      crc       <= '1;
      bcnt      <= '0;
      nb        <= '0;
      code      <= 2'b11;
      sr        <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      stat_vld  <= 1'b0;
      stat_byte <= STAT_RST;
    end else begin
      wr_en    <= 1'b0;
      stat_vld <= 1'b0;
      if (rx_en) ones <= rx_bit ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
      if (push) begin
        dly <= {rx_bit, dly[5:1]};
        if (fill != 3'd6) fill <= fill + 3'd1;
      end
      if (commit) begin
        crc  <= crc_n;
        sr   <= byte_n;
        bcnt <= bcnt + 3'd1;
      end
      if (byte_done) begin
        nb <= (nb == 2'd2) ? 2'd2 : nb + 2'd1;
        if (nb == 2'd1) la <= byte_n[0];
        if (first) begin
          cr   <= byte_n[1];
          code <= code_n;
          if (hit && !fifo_full) begin
            acc     <= 1'b1;
            wr_en   <= 1'b1;
            wr_data <= byte_n;
          end
        end else if (acc) begin
          if (fifo_full) ovf <= 1'b1;
          else begin
            wr_en   <= 1'b1;
            wr_data <= byte_n;
          end
        end
      end
      if (flag_hit) begin
        if (in_frm && acc) begin
          stat_vld  <= 1'b1;
          stat_byte <= {bcnt == 3'd0, ovf, crc_ok, 1'b0, code, cr, la};
        end
        in_frm <= 1'b1;
        fill   <= '0;
        crc    <= '1;
        bcnt   <= '0;
        nb     <= '0;
        acc    <= 1'b0;
        ovf    <= 1'b0;
        cr     <= 1'b0;
        la     <= 1'b0;
        code   <= 2'b11;
      end
      if (abort_hit) begin
        if (in_frm && acc) begin
          stat_vld  <= 1'b1;
          stat_byte <= {1'b0, ovf, 1'b0, 1'b1, code, cr, la};
        end
        in_frm <= 1'b0;
      end
    end
  end

  // R3
  wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en);

  // R3
  wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $past(rx_en));

  // R12
  stat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && stat_vld));

  // R12
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !stat_vld |-> $stable(stat_byte));

  // R2
  flag_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !stat_byte[4]) |-> ($past(rx_en) && !$past(rx_bit)));

  // R6
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && stat_byte[4]) |-> ($past(rx_en) && $past(rx_bit) && !stat_byte[7] && !stat_byte[5]));

endmodule

// File: tb/sim_hdlc_rx_status.sv
module sim_hdlc_rx_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_bit = 1'b1, addr_chk = 1'b0;
  logic [7:0] hi_addr1 = 8'h40, hi_addr2 = 8'h44;
  logic fifo_full;
  logic wr_en, stat_vld;
  logic [7:0] wr_data, stat_byte;

  int total = 0, bad = 0, gw = 0, gs = 0, wbase = 0, cap = 99, bones = 0;
  bit done = 1'b0;
  logic [7:0] wq[0:63];
  logic [7:0] sq[0:15];
  logic [7:0] d[0:7];

  always #4 clk = ~clk;

  assign fifo_full = (gw - wbase) >= cap;

  hdlc_rx_status u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit), .addr_chk(addr_chk),
    .hi_addr1(hi_addr1), .hi_addr2(hi_addr2), .fifo_full(fifo_full),
    .wr_en(wr_en), .wr_data(wr_data), .stat_vld(stat_vld), .stat_byte(stat_byte));

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin wq[gw[5:0]] = wr_data; gw = gw + 1; end
    if (stat_vld) begin sq[gs[3:0]] = stat_byte; gs = gs + 1; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {1'b0, c[15:1]} ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
  endfunction

  task automatic send_raw(input logic b);
    @(negedge clk); rx_en = 1'b1; rx_bit = b;
    @(negedge clk); rx_en = 1'b0;
  endtask

  task automatic send_data(input logic b);
    send_raw(b);
    if (b) begin
      bones++;
      if (bones == 5) begin send_raw(1'b0); bones = 0; end
    end else bones = 0;
  endtask

  task automatic send_flag;
    send_raw(1'b0);
    for (int k = 0; k < 6; k++) send_raw(1'b1);
    send_raw(1'b0);
    bones = 0;
  endtask

  task automatic frame(input int n, input int extra, input int cap_i, input bit badc,
                       input bit abrt, input string tag);
    logic [7:0] L[0:9];
    logic [15:0] c, mc;
    logic [1:0] cd;
    logic [7:0] es;
    int tot, comp, ew, sb;
    bit h, a, rdo;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      L[i] = d[i];
      for (int b = 0; b < 8; b++) c = crc_step(c, d[i][b]);
    end
    L[n] = ~c[7:0];
    L[n+1] = ~c[15:8];
    if (badc) L[n] = L[n] ^ 8'h01;
    tot = abrt ? n : n + 2;
    cap = cap_i; wbase = gw; sb = gs;
    mc = 16'hFFFF;
    for (int i = 0; i < tot; i++)
      for (int b = 0; b < 8; b++) begin send_data(L[i][b]); mc = crc_step(mc, L[i][b]); end
    for (int k = 0; k < extra; k++) begin send_data(k[0]); mc = crc_step(mc, k[0]); end
    if (abrt) begin
      for (int k = 0; k < 8; k++) send_raw(1'b1);
      send_flag();
    end else send_flag();
    repeat (4) @(negedge clk);
    comp = abrt ? n - 1 : tot;
    if (!addr_chk) begin h = 1; cd = 2'b11; end
    else if (L[0] == hi_addr1) begin h = 1; cd = 2'b10; end
    else if (L[0] == hi_addr2) begin h = 1; cd = 2'b00; end
    else if (L[0] == 8'hFE || L[0] == 8'hFC) begin h = 1; cd = 2'b01; end
    else begin h = 0; cd = 2'b11; end
    a = h && cap > 0 && comp >= 1;
    ew = a ? ((comp < cap) ? comp : cap) : 0;
    rdo = a && comp > cap;
    if (abrt) es = {1'b0, rdo, 1'b0, 1'b1, cd, L[0][1], (comp >= 2) ? L[1][0] : 1'b0};
    else es = {(extra % 8) == 0, rdo, mc == 16'hF0B8, 1'b0, cd, L[0][1], (tot >= 2) ? L[1][0] : 1'b0};
    chk(gs - sb == (a ? 1 : 0), {tag, " strobe count"}, gs - sb, a ? 1 : 0);
    if (a && gs - sb == 1) chk(sq[sb[3:0]] == es, {tag, " status"}, sq[sb[3:0]], es);
    if (!abrt) begin
      chk(gw - wbase == ew, {tag, " write count"}, gw - wbase, ew);
      for (int i = 0; i < ew && i < gw - wbase; i++) begin
        int ix = wbase + i;
        chk(wq[ix[5:0]] == L[i], {tag, " R3 byte"}, wq[ix[5:0]], L[i]);
      end
    end
    cap = 99;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(stat_byte == 8'h0E, "R1 reset status", stat_byte, 8'h0E);
    chk(!wr_en && !stat_vld, "R1 reset strobes", {wr_en, stat_vld}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 10; k++) send_raw(1'b1);
    send_flag();
    // R2 idle flags give no strobe
    begin
      int s0 = gs;
      send_flag(); send_flag(); send_raw(1'b1); send_flag(); send_flag();
      repeat (4) @(negedge clk);
      chk(gs == s0, "R2 idle flags", gs - s0, 0);
    end
    // R8 R3 R11 R2 lengths and stuffing patterns
    for (int n = 1; n <= 6; n++)
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < 8; i++)
          d[i] = (p == 0) ? 8'hFF : (p == 1) ? 8'h7E : (p == 2) ? 8'(i * 37 + n) : 8'h1F ^ 8'(i);
        frame(n, 0, 99, 0, 0, "R8");
      end
    // R7 sweep every first byte
    addr_chk = 1'b1; hi_addr1 = 8'h40; hi_addr2 = 8'h44;
    for (int v = 0; v < 256; v++) begin
      d[0] = 8'(v); d[1] = 8'(v) ^ 8'hA5;
      frame(2, 0, 99, 0, 0, "R7");
    end
    // R7 priority
    hi_addr1 = 8'hFE; hi_addr2 = 8'hFE; d[0] = 8'hFE; d[1] = 8'h03;
    frame(2, 0, 99, 0, 0, "R7 prio1");
    hi_addr1 = 8'h10; hi_addr2 = 8'hFC; d[0] = 8'hFC;
    frame(2, 0, 99, 0, 0, "R7 prio2");
    addr_chk = 1'b0;
    // R5 corrupted check sequence
    for (int n = 1; n <= 4; n++) begin
      for (int i = 0; i < 8; i++) d[i] = 8'(i * 91 + 3);
      frame(n, 0, 99, 1, 0, "R5");
    end
    // R4 non-aligned tails
    for (int e = 1; e < 8; e++) frame(3, e, 99, 0, 0, "R4");
    // R6 aborts
    for (int n = 3; n <= 5; n++) frame(n, 0, 99, 0, 1, "R6");
    // R9 R10 FIFO limits
    for (int i = 0; i < 8; i++) d[i] = 8'(8'h21 + i * 7);
    for (int cp = 0; cp <= 6; cp++) frame(4, 0, cp, 0, 0, (cp == 0) ? "R10" : "R9");
    // R11 single-byte frame, low flag 0
    d[0] = 8'h02; frame(1, 0, 99, 0, 0, "R11");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule